// File: doc/BRIEF.md
# Fuse Array Programming Register Front-End

This block is the software-facing register set of a one-time-programmable fuse array. A small synchronous register bus reaches a control register (with bit-set and bit-clear alias addresses), a timing register whose fields are passed straight to the fuse sequencer, and up to four data registers. Software stages a program access in three steps. It writes the target word address together with a 16-bit unlock key. In banked mode it fills data words 1 to 3. It then writes data word 0, which is the only write that can launch the operation.

When that final write is accepted, the block takes a private copy of the word address and sends a one-cycle request to the separate fuse-burning sequencer. It holds BUSY until the sequencer answers with done. Writes to a locked word never reach the sequencer and set a sticky ERROR flag instead. While ERROR stands, every new program or shadow-reload request is refused. A shadow reload is started from the control register and goes to the shadow store through its own request and done pair.

Top module: `fuse_regfront`

## Requirements
- R1: After reset, every register reads as zero, BUSY and ERROR are clear, and neither request output is high.
- R2: A plain write to the control register (offset 0x00) loads the word address in bits 7:0 and the unlock key in bits 31:16. BUSY (bit 8) and ERROR (bit 9) are not affected by a plain write. Writing bit 10 starts a shadow reload. Bits 15:11 always read zero.
- R3: A write to offset 0x04 ORs the written address and key bits into the control register. A write to offset 0x08 clears them, and it also clears ERROR when bit 9 is written as 1. Setting bit 9 through 0x04 has no effect. Both aliases read back the control register.
- R4: The timing register (offset 0x10) stores bits 21:0 and reads zero in bits 31:22. Bits 11:0 drive the program strobe output, bits 15:12 drive the relax output, and bits 21:16 drive the read strobe output.
- R5: Data registers sit at offsets 0x20, 0x30, 0x40 and 0x50; only 0x20 exists when banking is off. Unmapped offsets read zero, and reads change no state. Data word i drives bits 32i+31:32i of the program data output.
- R6: A write to data word 0 starts a program operation when BUSY is clear, ERROR is clear, the key equals 0x3E77 and the target word is unlocked. On acceptance, the program request goes high for exactly one cycle, BUSY sets, the key field clears, and the address is copied to the program address output. Writes to data words 1 to 3 never start an operation.
- R7: A write to data word 0 made without the correct key only stores the data. It raises no request, and the key field keeps its value.
- R8: While BUSY is set, the program address output holds its copy even when the control register address is rewritten.
- R9: While BUSY is set, writes to any data register are ignored and start nothing.
- R10: A keyed data word 0 write to a locked word raises no request and leaves BUSY clear. It sets ERROR and clears the key field.
- R11: While ERROR is set, keyed data writes and reload requests are refused. Once ERROR is cleared through offset 0x08, programming works again.
- R12: Writing bit 10 through offset 0x00 or 0x04 while the block is idle and ERROR is clear pulses the reload request for one cycle. It sets bit 10 and BUSY, and both clear when the reload completes.
- R13: BUSY clears in the cycle after the done input of the running operation is sampled high. A done input from the other kind of operation, or any done input while idle, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| lock_map | input | 2^ADDR_W | One lock bit per fuse word |
| prog_req | output | 1 | One-cycle program request to the sequencer |
| prog_addr | output | ADDR_W | Captured word address of the running program operation |
| prog_data | output | 32 x words | Data words, with word 0 in the low bits |
| prog_done | input | 1 | Sequencer reports that programming has finished |
| reload_req | output | 1 | One-cycle shadow reload request |
| reload_done | input | 1 | Shadow store reports that the reload has finished |
| tim_strobe_prog | output | 12 | Program strobe count |
| tim_relax | output | 4 | Relax count |
| tim_strobe_read | output | 6 | Read strobe count |

## Verification
A wrong key or lock decision shows up at the request output one clock after the data write. It also shows up in the ERROR and BUSY bits on the next control read. A corrupted address copy shows on the program address output while BUSY is held, so the bench rewrites the control address in the middle of an operation. A BUSY flag that clears too early or too late is seen at the exact control read around the done pulse. A refusal path that leaks shows up as a request pulse while ERROR is set.

// File: rtl/fuse_rf_pkg.sv
package fuse_rf_pkg;
    localparam int OFF_CTRL    = 'h00;
    localparam int OFF_SET     = 'h04;
    localparam int OFF_CLR     = 'h08;
    localparam int OFF_TIM     = 'h10;
    localparam int OFF_DATA0   = 'h20;
    localparam int DATA_STRIDE = 'h10;
    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam int TIM_W = 22;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_RELOAD = 2'd2
    } op_e;

    typedef struct packed {
        logic ctrl;
        logic set;
        logic clr;
        logic tim;
    } hit_t;
endpackage

// File: rtl/fuse_rf_decode.sv
module fuse_rf_decode
    import fuse_rf_pkg::*;
#(
    parameter int NDATA = 4
) (
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    output hit_t             wr_hit,
    output hit_t             rd_hit,
    output logic [NDATA-1:0] wr_data_hit,
    output logic [NDATA-1:0] rd_data_hit
);
    hit_t             match;
    logic [NDATA-1:0] data_match;

    for (genvar g = 0; g < NDATA; g++) begin : g_data
        localparam int OFS = OFF_DATA0 + g * DATA_STRIDE;
        assign data_match[g] = (bus_addr == 8'(OFS));
    end

    always_comb begin
        match.ctrl  = (bus_addr == 8'(OFF_CTRL));
        match.set   = (bus_addr == 8'(OFF_SET));
        match.clr   = (bus_addr == 8'(OFF_CLR));
        match.tim   = (bus_addr == 8'(OFF_TIM));
        wr_hit      = '0;
        rd_hit      = '0;
        wr_data_hit = '0;
        rd_data_hit = '0;
        if (bus_sel && bus_wr) begin
            wr_hit      = match;
            wr_data_hit = data_match;
        end
        if (bus_sel && !bus_wr) begin
            rd_hit      = match;
            rd_data_hit = data_match;
        end
    end
endmodule

// File: rtl/fuse_rf_databank.sv
module fuse_rf_databank #(
    parameter int NDATA = 4,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NDATA-1:0]    wr_en,
    input  logic [DW-1:0]       wdata,
    output logic [NDATA*DW-1:0] words
);
    logic [DW-1:0] word_d [NDATA];
    logic [DW-1:0] word_q [NDATA];

    always_comb begin
        for (int i = 0; i < NDATA; i++) begin
            word_d[i] = wr_en[i] ? wdata : word_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDATA; i++) word_q[i] <= '0;
        end else begin
            for (int i = 0; i < NDATA; i++) word_q[i] <= word_d[i];
        end
    end

    for (genvar g = 0; g < NDATA; g++) begin : g_out
        assign words[g*DW +: DW] = word_q[g];
    end
endmodule

// File: rtl/fuse_rf_lockchk.sv
module fuse_rf_lockchk #(
    parameter int ADDR_W = 8
) (
    input  logic [(1<<ADDR_W)-1:0] lock_map,
    input  logic [ADDR_W-1:0]      addr,
    output logic                   locked
);
    assign locked = lock_map[addr];
endmodule

// File: rtl/fuse_regfront.sv
module fuse_regfront
    import fuse_rf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter bit BANKED = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [7:0]                    bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [(1<<ADDR_W)-1:0]        lock_map,
    output logic                          prog_req,
    output logic [ADDR_W-1:0]             prog_addr,
    output logic [(BANKED ? 4 : 1)*32-1:0] prog_data,
    input  logic                          prog_done,
    output logic                          reload_req,
    input  logic                          reload_done,
    output logic [11:0]                   tim_strobe_prog,
    output logic [3:0]                    tim_relax,
    output logic [5:0]                    tim_strobe_read
);
    localparam int NDATA  = BANKED ? 4 : 1;
    localparam int BUSY_B = ADDR_W;
    localparam int ERR_B  = ADDR_W + 1;
    localparam int RLD_B  = ADDR_W + 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [15:0]       key;
        logic              busy;
        logic              err;
        logic              rld;
        op_e               op;
        logic [ADDR_W-1:0] copy;
        logic              preq;
        logic              rreq;
        logic [TIM_W-1:0]  tim;
    } state_t;

    state_t s_d, s_q;

    hit_t             wr_hit, rd_hit;
    logic [NDATA-1:0] wr_data_hit, rd_data_hit;
    logic [NDATA-1:0] bank_we;
    logic             locked;
    logic             start_rld;
    logic [31:0]      ctrl_view;
    logic             busy;
    logic             err;
    logic             rld;

    fuse_rf_decode #(.NDATA(NDATA)) u_decode (
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .wr_hit      (wr_hit),
        .rd_hit      (rd_hit),
        .wr_data_hit (wr_data_hit),
        .rd_data_hit (rd_data_hit)
    );

    assign bank_we = wr_data_hit & {NDATA{~s_q.busy}};

    fuse_rf_databank #(.NDATA(NDATA), .DW(32)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_we),
        .wdata (bus_wdata),
        .words (prog_data)
    );

    fuse_rf_lockchk #(.ADDR_W(ADDR_W)) u_lock (
        .lock_map (lock_map),
        .addr     (s_q.addr),
        .locked   (locked)
    );

    always_comb begin
        s_d       = s_q;
        s_d.preq  = 1'b0;
        s_d.rreq  = 1'b0;
        start_rld = 1'b0;

        if (s_q.busy) begin
            if ((s_q.op == OP_PROG && prog_done) ||
                (s_q.op == OP_RELOAD && reload_done)) begin
                s_d.busy = 1'b0;
                s_d.rld  = 1'b0;
                s_d.op   = OP_IDLE;
            end
        end

        if (wr_hit.ctrl) begin
            s_d.addr  = bus_wdata[ADDR_W-1:0];
            s_d.key   = bus_wdata[31:16];
            start_rld = bus_wdata[RLD_B];
        end
        if (wr_hit.set) begin
            s_d.addr  = s_q.addr | bus_wdata[ADDR_W-1:0];
            s_d.key   = s_q.key | bus_wdata[31:16];
            start_rld = bus_wdata[RLD_B];
        end
        if (wr_hit.clr) begin
            s_d.addr = s_q.addr & ~bus_wdata[ADDR_W-1:0];
            s_d.key  = s_q.key & ~bus_wdata[31:16];
            if (bus_wdata[ERR_B]) s_d.err = 1'b0;
        end

        if (start_rld && !s_q.busy && !s_q.err) begin
            s_d.busy = 1'b1;
            s_d.rld  = 1'b1;
            s_d.op   = OP_RELOAD;
            s_d.rreq = 1'b1;
        end

        if (wr_hit.tim) s_d.tim = bus_wdata[TIM_W-1:0];

        if (wr_data_hit[0] && !s_q.busy && s_q.key == UNLOCK_KEY) begin
            s_d.key = '0;
            if (!s_q.err) begin
                if (locked) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.op   = OP_PROG;
                    s_d.preq = 1'b1;
                    s_d.copy = s_q.addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctrl_view               = '0;
        ctrl_view[ADDR_W-1:0]   = s_q.addr;
        ctrl_view[BUSY_B]       = s_q.busy;
        ctrl_view[ERR_B]        = s_q.err;
        ctrl_view[RLD_B]        = s_q.rld;
        ctrl_view[31:16]        = s_q.key;

        bus_rdata = '0;
        if (rd_hit.ctrl || rd_hit.set || rd_hit.clr) bus_rdata = ctrl_view;
        if (rd_hit.tim) bus_rdata = 32'(s_q.tim);
        for (int i = 0; i < NDATA; i++) begin
            if (rd_data_hit[i]) bus_rdata = prog_data[i*32 +: 32];
        end
    end

    assign busy            = s_q.busy;
    assign err             = s_q.err;
    assign rld             = s_q.rld;
    assign prog_req        = s_q.preq;
    assign reload_req      = s_q.rreq;
    assign prog_addr       = s_q.copy;
    assign tim_strobe_prog = s_q.tim[11:0];
    assign tim_relax       = s_q.tim[15:12];
    assign tim_strobe_read = s_q.tim[21:16];
endmodule

// File: rtl/fuse_rf_chk.sv
module fuse_rf_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              err,
    input logic              rld,
    input logic              prog_req,
    input logic              reload_req,
    input logic              prog_done,
    input logic              reload_done,
    input logic [ADDR_W-1:0] prog_addr
);
    // R6
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R6
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> busy);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(prog_addr));

    // R11
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!prog_req && !reload_req));

    // R12
    rld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_req |=> !reload_req);

    // R13
    prog_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rld && prog_done) |=> !busy);

    // R13
    rld_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rld && reload_done) |=> !busy);
endmodule

bind fuse_regfront fuse_rf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .err         (err),
    .rld         (rld),
    .prog_req    (prog_req),
    .reload_req  (reload_req),
    .prog_done   (prog_done),
    .reload_done (reload_done),
    .prog_addr   (prog_addr)
);

// File: tb/fuse_regfront_tb.sv
module fuse_regfront_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] lock_map = '0;
    logic         prog_req;
    logic [7:0]   prog_addr;
    logic [127:0] prog_data;
    logic         prog_done = 1'b0;
    logic         reload_req;
    logic         reload_done = 1'b0;
    logic [11:0]  tim_strobe_prog;
    logic [3:0]   tim_relax;
    logic [5:0]   tim_strobe_read;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_regfront #(.ADDR_W(8), .BANKED(1'b1)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .lock_map (lock_map),
        .prog_req (prog_req), .prog_addr (prog_addr), .prog_data (prog_data),
        .prog_done (prog_done),
        .reload_req (reload_req), .reload_done (reload_done),
        .tim_strobe_prog (tim_strobe_prog), .tim_relax (tim_relax),
        .tim_strobe_read (tim_strobe_read)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 22;
    // Tags: R2 R3 R4 R5
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h10, 32'hFFFF_FFFF, 4'd4},
        '{1'b0, 8'h10, 32'h003F_FFFF, 4'd4},
        '{1'b1, 8'h00, 32'h0000_0055, 4'd2},
        '{1'b0, 8'h00, 32'h0000_0055, 4'd2},
        '{1'b1, 8'h04, 32'h0000_00A0, 4'd3},
        '{1'b0, 8'h00, 32'h0000_00F5, 4'd3},
        '{1'b1, 8'h08, 32'h0000_0005, 4'd3},
        '{1'b0, 8'h00, 32'h0000_00F0, 4'd3},
        '{1'b1, 8'h00, 32'h0000_FB12, 4'd2},
        '{1'b0, 8'h00, 32'h0000_0012, 4'd2},
        '{1'b1, 8'h00, 32'h1234_0000, 4'd2},
        '{1'b0, 8'h00, 32'h1234_0000, 4'd2},
        '{1'b1, 8'h08, 32'hFFFF_0000, 4'd3},
        '{1'b0, 8'h08, 32'h0000_0000, 4'd3},
        '{1'b1, 8'h30, 32'hA5A5_0001, 4'd5},
        '{1'b0, 8'h30, 32'hA5A5_0001, 4'd5},
        '{1'b1, 8'h40, 32'hA5A5_0002, 4'd5},
        '{1'b0, 8'h40, 32'hA5A5_0002, 4'd5},
        '{1'b1, 8'h50, 32'hA5A5_0003, 4'd5},
        '{1'b0, 8'h50, 32'hA5A5_0003, 4'd5},
        '{1'b0, 8'h60, 32'h0000_0000, 4'd5},
        '{1'b0, 8'h10, 32'h003F_FFFF, 4'd5}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        brd(a, v);
        chk(req, v, exp);
    endtask

    task automatic done_pulse(input bit is_prog);
        @(negedge clk);
        if (is_prog) prog_done = 1'b1; else reload_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0; reload_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 prog_req", prog_req, 0);
        chk("R1 reload_req", reload_req, 0);
        rchk("R1 ctrl", 8'h00, 32'h0);
        rchk("R1 timing", 8'h10, 32'h0);
        rchk("R1 data0", 8'h20, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) bwr(TBL[i].addr, TBL[i].data);
            else rchk($sformatf("R%0d table %0d", TBL[i].rq, i), TBL[i].addr, TBL[i].data);
        end

        // R4 timing outputs
        chk("R4 strobe_prog", tim_strobe_prog, 12'hFFF);
        chk("R4 relax", tim_relax, 4'hF);
        chk("R4 strobe_read", tim_strobe_read, 6'h3F);

        // R7 unkeyed data write
        bwr(8'h20, 32'h11);
        chk("R7 no req", prog_req, 0);
        rchk("R7 ctrl", 8'h00, 32'h0);
        rchk("R5 data0", 8'h20, 32'h11);
        bwr(8'h00, 32'h3E76_0005);
        bwr(8'h20, 32'h22);
        chk("R7 wrong key no req", prog_req, 0);
        rchk("R7 key kept", 8'h00, 32'h3E76_0005);

        // R6 program sequence
        bwr(8'h30, 32'h1);
        bwr(8'h40, 32'h2);
        bwr(8'h50, 32'h3);
        chk("R6 no req from data1-3", prog_req, 0);
        bwr(8'h00, 32'h3E77_0007);
        rchk("R2 key and addr", 8'h00, 32'h3E77_0007);
        bwr(8'h20, 32'hC0DE);
        chk("R6 req", prog_req, 1);
        chk("R6 addr copy", prog_addr, 8'h07);
        chk("R5 prog_data", prog_data, {32'h3, 32'h2, 32'h1, 32'hC0DE});
        rchk("R6 busy key cleared", 8'h00, 32'h0000_0107);
        chk("R6 pulse one cycle", prog_req, 0);

        // R9 data ignored while busy
        bwr(8'h30, 32'h99);
        rchk("R9 data1 kept", 8'h30, 32'h1);
        bwr(8'h20, 32'hFFFF);
        rchk("R9 data0 kept", 8'h20, 32'hC0DE);
        bwr(8'h00, 32'h3E77_0033);
        chk("R8 addr copy held", prog_addr, 8'h07);
        bwr(8'h20, 32'h5);
        chk("R9 no req while busy", prog_req, 0);
        rchk("R8 ctrl addr rewritten", 8'h00, 32'h3E77_0133);
        bwr(8'h08, 32'hFFFF_0000);

        // R13 wrong done while programming
        done_pulse(1'b0);
        rchk("R13 reload_done ignored", 8'h00, 32'h0000_0133);
        @(negedge clk);
        prog_done = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        #1;
        chk("R13 busy during done", bus_rdata, 32'h0000_0133);
        @(negedge clk);
        prog_done = 1'b0;
        #1;
        chk("R13 busy cleared", bus_rdata, 32'h0000_0033);
        bus_sel = 1'b0;
        done_pulse(1'b1);
        rchk("R13 idle done ignored", 8'h00, 32'h0000_0033);

        // R10 locked word
        lock_map[8'h40] = 1'b1;
        bwr(8'h00, 32'h3E77_0040);
        bwr(8'h20, 32'h5);
        chk("R10 no req", prog_req, 0);
        rchk("R10 error set", 8'h00, 32'h0000_0240);

        // R11 refusal while ERROR
        bwr(8'h00, 32'h3E77_0041);
        bwr(8'h20, 32'h6);
        chk("R11 prog refused", prog_req, 0);
        rchk("R11 ctrl", 8'h00, 32'h0000_0241);
        bwr(8'h04, 32'h0000_0400);
        chk("R11 reload refused", reload_req, 0);
        rchk("R11 no reload bit", 8'h00, 32'h0000_0241);
        bwr(8'h00, 32'h0000_0041);
        rchk("R2 plain write keeps error", 8'h00, 32'h0000_0241);
        bwr(8'h04, 32'h0000_0200);
        rchk("R3 set alias cannot touch error", 8'h00, 32'h0000_0241);
        bwr(8'h08, 32'h0000_0200);
        rchk("R3 clr alias clears error", 8'h00, 32'h0000_0041);
        bwr(8'h00, 32'h3E77_0041);
        bwr(8'h20, 32'h7);
        chk("R11 prog after clear", prog_req, 1);
        chk("R11 addr after clear", prog_addr, 8'h41);
        done_pulse(1'b1);
        rchk("R13 idle again", 8'h00, 32'h0000_0041);

        // R12 shadow reload
        bwr(8'h04, 32'h0000_0400);
        chk("R12 reload req", reload_req, 1);
        rchk("R12 reload busy", 8'h00, 32'h0000_0541);
        chk("R12 reload pulse", reload_req, 0);
        done_pulse(1'b1);
        rchk("R13 prog_done ignored in reload", 8'h00, 32'h0000_0541);
        done_pulse(1'b0);
        rchk("R12 reload done", 8'h00, 32'h0000_0041);
        bwr(8'h00, 32'h0000_0441);
        chk("R12 plain reload req", reload_req, 1);
        rchk("R12 plain reload busy", 8'h00, 32'h0000_0541);
        done_pulse(1'b0);
        rchk("R12 plain reload done", 8'h00, 32'h0000_0041);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule